// File: doc/BRIEF.md
# Input Pin Change Detector with Interrupt

This block watches a small group of asynchronous input pins. Every pin is brought into the clock domain through a short flop chain. The resynchronised levels are then kept in a level register. The lower group of pins (four by default) also has change tracking: a capture word reports their present levels in its low half and one sticky "has changed" flag per pin in its high half.

A per-pin enable register selects which of the tracked pins may raise the shared change-status bit. The interrupt line is that status bit gated by an externally held mask bit. The upper pins (two by default) have their levels tracked only, with no flags.

Software reads the capture word to collect and acknowledge changes. That read clears every flag and the status bit. Writing the enable register can raise the status bit after the fact when a newly enabled pin already has a pending flag. A change that lands in the same cycle as the acknowledging read is not lost.

Top module: `pin_change_irq`

## Requirements
- R1: After reset, the capture word, the level word, the status bit and the interrupt line are all zero.
- R2: Bits [3:0] of the capture word show the levels of tracked pins 3..0. A pin change appears there at the third rising clock edge after the pin changes (two synchroniser edges plus one capture edge).
- R3: A level change on tracked pin n (n = 0..3) sets capture bit 4+n in that same edge, and the bit stays set until a capture read.
- R4: If enable bit n is set when tracked pin n changes, the change-status bit is set at that edge.
- R5: A capture read returns the pre-clear value. At the following edge all flags [7:4] and the status bit clear unless a new event sets them in that edge.
- R6: An enable-register write whose data bits [3:0] overlap a flag that is pending at that edge sets the status bit.
- R7: Pins 4 and 5 appear on bits [5:4] of the level word with the same latency as R2, and they never set a flag or the status bit.
- R8: When a tracked pin change and a capture read fall on the same edge, that pin's flag ends up set while the other flags clear. An enabled change likewise leaves the status bit set.
- R9: The interrupt line equals the status bit AND the mask input. It is combinational from the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 6 | Asynchronous input pins |
| cap_rd | input | 1 | Capture-word read strobe (acknowledge) |
| cap_rdata | output | 8 | Capture word: {flags[3:0], levels[3:0]} |
| ctl_we | input | 1 | Enable-register write strobe |
| ctl_wdata | input | 4 | Per-pin change-interrupt enables |
| irq_mask | input | 1 | Interrupt mask for the change-status bit |
| lvl_rdata | output | 6 | Resynchronised levels of all pins |
| chg_status | output | 1 | Shared change-status bit |
| irq | output | 1 | Interrupt output |

## Verification
Two events can collide at a single edge. One is a capture read that clears the flags. The other is a new pin change, or an enable write, that sets them. The bench times the pin toggle so that its third edge carries the read strobe, and it also randomises reads, writes and pins over many cycles. A behavioural model applies the rule that a set beats a clear, and it compares every output on every cycle, so a design that loses the colliding event is reported.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
   function automatic logic any_overlap(input logic [7:0] a, input logic [7:0] b);
      return |(a & b);
   endfunction
endpackage

// File: rtl/pcd_sync.sv
module pcd_sync #(
   parameter int W      = 6,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pcd_capture.sv
module pcd_capture #(
   parameter int N_PINS  = 6,
   parameter int N_TRACK = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_PINS-1:0]  sync_lvl,
   input  logic               cap_rd,
   output logic [N_PINS-1:0]  lvl_q,
   output logic [N_TRACK-1:0] flags_q,
   output logic [N_TRACK-1:0] change
);
   assign change = sync_lvl[N_TRACK-1:0] ^ lvl_q[N_TRACK-1:0];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= sync_lvl;

   for (genvar n = 0; n < N_TRACK; n++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)         flags_q[n] <= 1'b0;
         else if (change[n]) flags_q[n] <= 1'b1;
         else if (cap_rd)    flags_q[n] <= 1'b0;
   end
endmodule

// File: rtl/pcd_status.sv
module pcd_status #(
   parameter int N_TRACK = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_TRACK-1:0] change,
   input  logic [N_TRACK-1:0] flags_q,
   input  logic               cap_rd,
   input  logic               ctl_we,
   input  logic [N_TRACK-1:0] ctl_wdata,
   input  logic               irq_mask,
   output logic               status_q,
   output logic               irq
);
   import pcd_pkg::*;
   logic [N_TRACK-1:0] en_q;
   logic               set_ev;

   always_comb begin
      set_ev = |(change & en_q);
      if (ctl_we && any_overlap(8'(ctl_wdata), 8'(flags_q))) set_ev = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      en_q <= '0;
      else if (ctl_we) en_q <= ctl_wdata;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      status_q <= 1'b0;
      else if (set_ev) status_q <= 1'b1;
      else if (cap_rd) status_q <= 1'b0;

   assign irq = status_q & irq_mask;
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
   parameter int N_PINS      = 6,
   parameter int N_TRACK     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_PINS-1:0]      pin_in,
   input  logic                   cap_rd,
   output logic [2*N_TRACK-1:0]   cap_rdata,
   input  logic                   ctl_we,
   input  logic [N_TRACK-1:0]     ctl_wdata,
   input  logic                   irq_mask,
   output logic [N_PINS-1:0]      lvl_rdata,
   output logic                   chg_status,
   output logic                   irq
);
   if (N_TRACK < 1 || N_TRACK > N_PINS || N_TRACK > 8) begin : g_bad_track
      $error("N_TRACK must lie in 1..min(N_PINS,8)");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   logic [N_PINS-1:0]  sync_lvl;
   logic [N_PINS-1:0]  lvl_q;
   logic [N_TRACK-1:0] flags_q;
   logic [N_TRACK-1:0] change;

   pcd_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_lvl));

   pcd_capture #(.N_PINS(N_PINS), .N_TRACK(N_TRACK)) u_cap (
      .clk(clk), .rst_n(rst_n), .sync_lvl(sync_lvl), .cap_rd(cap_rd),
      .lvl_q(lvl_q), .flags_q(flags_q), .change(change));

   pcd_status #(.N_TRACK(N_TRACK)) u_stat (
      .clk(clk), .rst_n(rst_n), .change(change), .flags_q(flags_q),
      .cap_rd(cap_rd), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .irq_mask(irq_mask), .status_q(chg_status), .irq(irq));

   assign cap_rdata = {flags_q, lvl_q[N_TRACK-1:0]};
   assign lvl_rdata = lvl_q;
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
   parameter int N_PINS  = 6,
   parameter int N_TRACK = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cap_rd,
   input logic [2*N_TRACK-1:0] cap_rdata,
   input logic                 ctl_we,
   input logic                 irq_mask,
   input logic [N_PINS-1:0]    lvl_rdata,
   input logic                 chg_status,
   input logic                 irq
);
   localparam int T = N_TRACK;

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_rd |=> ((cap_rdata[2*T-1:T] & $past(cap_rdata[2*T-1:T])) == $past(cap_rdata[2*T-1:T]))); // R3

   AST_CHANGE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_rdata[T-1:0]) |->
         ((cap_rdata[2*T-1:T] & (cap_rdata[T-1:0] ^ $past(cap_rdata[T-1:0])))
          == (cap_rdata[T-1:0] ^ $past(cap_rdata[T-1:0])))); // R8

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      cap_rd |=> ($stable(cap_rdata[T-1:0]) -> (cap_rdata[2*T-1:T] == '0))); // R5

   AST_STATUS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chg_status) |-> ($past(ctl_we) || !$stable(cap_rdata[T-1:0]))); // R4

   AST_UPPER_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(lvl_rdata) && $stable(lvl_rdata[T-1:0])) |->
         ((cap_rdata[2*T-1:T] & ~$past(cap_rdata[2*T-1:T])) == '0)); // R7

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_mask |-> !irq); // R9

   AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> chg_status); // R9
endmodule

bind pin_change_irq pcd_checker #(.N_PINS(N_PINS), .N_TRACK(N_TRACK)) u_chk (
   .clk(clk), .rst_n(rst_n), .cap_rd(cap_rd), .cap_rdata(cap_rdata),
   .ctl_we(ctl_we), .irq_mask(irq_mask), .lvl_rdata(lvl_rdata),
   .chg_status(chg_status), .irq(irq));

// File: tb/pin_change_irq_test.sv
`timescale 1ns/1ps
module pin_change_irq_test;
   logic       clk = 0;
   logic       rst_n = 0;
   logic [5:0] pin_in = '0;
   logic       cap_rd = 0;
   logic       ctl_we = 0;
   logic [3:0] ctl_wdata = '0;
   logic       irq_mask = 0;
   logic [7:0] cap_rdata;
   logic [5:0] lvl_rdata;
   logic       chg_status, irq;

   int errors = 0, checks = 0, cyc = 0;
   bit done = 0;

   always #4 clk = ~clk;

   pin_change_irq uut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cap_rd(cap_rd),
      .cap_rdata(cap_rdata), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .irq_mask(irq_mask), .lvl_rdata(lvl_rdata), .chg_status(chg_status),
      .irq(irq));

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // behavioural reference model
   logic [5:0] hq[$];
   logic [5:0] m_lvl;
   logic [3:0] m_flags, m_en;
   logic       m_st;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         hq = {6'd0, 6'd0};
         m_lvl = 0; m_flags = 0; m_en = 0; m_st = 0;
      end else begin
         logic [5:0] d;
         logic [3:0] ch;
         logic       s;
         hq.push_back(pin_in);
         d  = hq.pop_front();
         ch = d[3:0] ^ m_lvl[3:0];
         s  = |(ch & m_en) || (ctl_we && |(ctl_wdata & m_flags));
         m_flags = (cap_rd ? 4'h0 : m_flags) | ch;
         m_st    = s ? 1'b1 : (cap_rd ? 1'b0 : m_st);
         if (ctl_we) m_en = ctl_wdata;
         m_lvl = d;
      end
   end

   // per-cycle comparison, 2 ns after the edge
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         chk("R2 levels", cap_rdata[3:0], m_lvl[3:0]);
         chk("R3/R5/R8 flags", cap_rdata[7:4], m_flags);
         chk("R7 level word", lvl_rdata, m_lvl);
         chk("R4/R6 status", chg_status, m_st);
         chk("R9 irq", irq, m_st & irq_mask);
      end
   end

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      tick(3);
      chk("R1 cap", cap_rdata, 0);
      chk("R1 lvl", lvl_rdata, 0);
      chk("R1 irq", irq, 0);
      rst_n = 1;
      tick(2);
      // R2/R3: toggle pin 0, not enabled
      pin_in[0] = 1; tick(4);
      chk("R3 cap after pin0", cap_rdata, 8'h11);
      chk("R4 no status when disabled", chg_status, 0);
      // R5: read clears
      cap_rd = 1; tick(); cap_rd = 0;
      chk("R5 cleared", cap_rdata, 8'h01);
      // R6: enable write after pending flag
      ctl_we = 1; ctl_wdata = 4'b0001; tick(); ctl_we = 0;
      pin_in[1] = 1; tick(4);
      chk("R6 status not yet", chg_status, 0);
      ctl_we = 1; ctl_wdata = 4'b0011; tick(); ctl_we = 0;
      chk("R6 status set by write", chg_status, 1);
      irq_mask = 1; #1;
      chk("R9 irq with mask", irq, 1);
      irq_mask = 0; #1;
      chk("R9 irq masked", irq, 0);
      cap_rd = 1; tick(); cap_rd = 0;
      chk("R5 status cleared", chg_status, 0);
      // R4: enabled change
      ctl_we = 1; ctl_wdata = 4'b0100; tick(); ctl_we = 0;
      pin_in[2] = 1; tick(4);
      chk("R4 status on enabled change", chg_status, 1);
      cap_rd = 1; tick(); cap_rd = 0;
      // R7: upper pins
      pin_in[5:4] = 2'b11; tick(4);
      chk("R7 upper levels", lvl_rdata[5:4], 2'b11);
      chk("R7 no flags", cap_rdata[7:4], 0);
      chk("R7 no status", chg_status, 0);
      // R8: collision of change and read on one edge
      pin_in[0] = 0; tick(4);        // flag 0 pending
      ctl_we = 1; ctl_wdata = 4'b1000; tick(); ctl_we = 0;
      pin_in[3] = 1; tick(2);
      cap_rd = 1; tick(); cap_rd = 0;
      chk("R8 flag3 survives read", cap_rdata[7:4], 4'b1000);
      chk("R8 status survives read", chg_status, 1);
      cap_rd = 1; tick(); cap_rd = 0;
      // random traffic
      for (int i = 0; i < 600; i++) begin
         if ($urandom_range(0, 3) == 0) pin_in = 6'($urandom);
         cap_rd    = ($urandom_range(0, 5) == 0);
         ctl_we    = ($urandom_range(0, 7) == 0);
         ctl_wdata = 4'($urandom);
         irq_mask  = 1'($urandom);
         tick();
      end
      cap_rd = 0; ctl_we = 0;
      tick(2);
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule